// File: doc/BRIEF.md
# Floating-point compare condition-code generator

This block compares two IEEE-754 operands, in single (32-bit) or double (64-bit) precision, and produces the 2-bit floating-point condition code that a following branch unit decodes. A request carries a 9-bit operation field, the two operands and the current 32-bit floating-point status word. One cycle later the block returns the status word. If the request succeeded, the two condition-code bits in that word hold the new code. If it did not, the word comes back unchanged.

Two flavours of compare exist. An ordinary compare reports NaN operands as "unordered". A signalling compare instead raises an invalid-operation trap and leaves the status untouched. Selector values outside the four defined compares are flagged as illegal operations. Control decodes the selector into a small strobe bundle. The datapath holds one comparator per precision and the output register.

Top module: `fcc_top`

## Requirements
- R1: The operation field selects the compare: 0x51 is the single ordinary compare, 0x52 the double ordinary compare, 0x55 the single signalling compare and 0x56 the double signalling compare. Single compares use only bits 31:0 of each operand and ignore bits 63:32.
- R2: For non-NaN operands the code is 0 when A equals B, 1 when A is less than B and 2 when A is greater than B. The code is written to status bits 11:10 and `ccWritten` pulses.
- R3: In an ordinary compare, a NaN in either operand gives code 3 (unordered). A NaN has an all-ones exponent and a non-zero fraction.
- R4: In a signalling compare, a NaN operand pulses `invalidTrap`. In that case `ccWritten` stays low and `statusOut` equals the status word given with the request.
- R5: On a successful compare, every status bit other than 11:10 equals the status word given with the request.
- R6: Any other operation field value pulses `illegalOp` and returns the given status word unchanged.
- R7: Positive zero and negative zero compare equal, at both precisions.
- R8: Non-NaN operands are ordered by sign and magnitude. Any negative value is below any positive value. Between two negatives, the one with the larger magnitude is the smaller value. Infinities take part in this ordering.
- R9: A request sampled on a clock edge produces a one-cycle `doneValid` pulse and its result on the next edge. Back-to-back requests are accepted every cycle, and `statusOut` holds its value while no result is presented.
- R10: While reset is asserted (`rstN` low), `statusOut` is zero and all pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Request present this cycle |
| opField | input | 9 | Operation selector |
| opA | input | 64 | First operand (single precision in bits 31:0) |
| opB | input | 64 | Second operand (single precision in bits 31:0) |
| statusIn | input | 32 | Status word accompanying the request |
| doneValid | output | 1 | One-cycle result pulse |
| ccWritten | output | 1 | Condition code was written |
| invalidTrap | output | 1 | Signalling compare saw a NaN |
| illegalOp | output | 1 | Selector not a defined compare |
| statusOut | output | 32 | Updated or preserved status word |

## Verification
The bench builds the block with its default parameters: a 32-bit single comparator with an 8-bit exponent, a 64-bit double comparator with an 11-bit exponent, and the code field at bits 11:10. These values bring the real selector encodings within reach. They also make it possible to compare both precisions against the simulator's own double-precision ordering, with single operands widened exactly. Stimulus covers signed zeros, infinities, negative ordering, NaNs in either operand, garbage in the unused upper half for single compares, and several illegal selectors. Back-to-back requests are mixed with idle gaps, so that output holding and single-cycle pulses are observed.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  localparam int OP_W = 9;

  localparam logic [OP_W-1:0] OP_CMP_SGL  = 9'h051;
  localparam logic [OP_W-1:0] OP_CMP_DBL  = 9'h052;
  localparam logic [OP_W-1:0] OP_CMPX_SGL = 9'h055;
  localparam logic [OP_W-1:0] OP_CMPX_DBL = 9'h056;

  typedef enum logic [1:0] {
    CC_EQ = 2'd0,
    CC_LT = 2'd1,
    CC_GT = 2'd2,
    CC_UN = 2'd3
  } ccCode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic useDouble;
    logic signalling;
    logic illegal;
  } fccStrobe_t;

endpackage

// File: rtl/fcc_cmp.sv
// Sign-magnitude compare of two IEEE-754 values of one precision
module fcc_cmp
  import fcc_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int EXP_W = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output ccCode_t          cc,
  output logic             anyNan
);

  localparam int MAN_W = WIDTH - 1 - EXP_W;

  logic             signA, signB;
  logic [WIDTH-2:0] magA, magB;
  logic             nanA, nanB;
  logic             bothZero;

  always_comb begin
    signA    = a[WIDTH-1];
    signB    = b[WIDTH-1];
    magA     = a[WIDTH-2:0];
    magB     = b[WIDTH-2:0];
    nanA     = (&a[WIDTH-2 -: EXP_W]) && (|a[MAN_W-1:0]);
    nanB     = (&b[WIDTH-2 -: EXP_W]) && (|b[MAN_W-1:0]);
    anyNan   = nanA || nanB;
    bothZero = (magA == '0) && (magB == '0);

    if (anyNan)                    cc = CC_UN;
    else if (bothZero || a == b)   cc = CC_EQ;
    else if (signA != signB)       cc = signA ? CC_LT : CC_GT;
    else if (!signA)               cc = (magA < magB) ? CC_LT : CC_GT;
    else                           cc = (magA > magB) ? CC_LT : CC_GT;
  end

endmodule

// File: rtl/fcc_ctrl.sv
// Selector decode into datapath strobes
module fcc_ctrl
  import fcc_pkg::*;
(
  input  logic            startValid,
  input  logic [OP_W-1:0] opField,
  output fccStrobe_t      strb
);

  always_comb begin
    strb            = '0;
    strb.load       = startValid;
    unique case (opField)
      OP_CMP_SGL:  begin strb.useDouble = 1'b0; strb.signalling = 1'b0; end
      OP_CMP_DBL:  begin strb.useDouble = 1'b1; strb.signalling = 1'b0; end
      OP_CMPX_SGL: begin strb.useDouble = 1'b0; strb.signalling = 1'b1; end
      OP_CMPX_DBL: begin strb.useDouble = 1'b1; strb.signalling = 1'b1; end
      default:     strb.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/fcc_datapath.sv
// Comparators, status merge and output register
module fcc_datapath
  import fcc_pkg::*;
#(
  parameter int SGL_W  = 32,
  parameter int SGL_EXP = 8,
  parameter int DBL_W  = 64,
  parameter int DBL_EXP = 11,
  parameter int STAT_W = 32,
  parameter int CC_LSB = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  fccStrobe_t        strb,
  input  logic [DBL_W-1:0]  opA,
  input  logic [DBL_W-1:0]  opB,
  input  logic [STAT_W-1:0] statusIn,
  output logic              doneValid,
  output logic              ccWritten,
  output logic              invalidTrap,
  output logic              illegalOp,
  output logic [STAT_W-1:0] statusOut
);

  localparam logic [STAT_W-1:0] CC_MASK = STAT_W'(3) << CC_LSB;

  ccCode_t           sglCc, dblCc, selCc;
  logic              sglNan, dblNan, selNan;
  logic              fault;
  logic [STAT_W-1:0] mergedStatus;

  fcc_cmp #(.WIDTH(SGL_W), .EXP_W(SGL_EXP)) sglCmp_i (
    .a(opA[SGL_W-1:0]), .b(opB[SGL_W-1:0]), .cc(sglCc), .anyNan(sglNan)
  );

  fcc_cmp #(.WIDTH(DBL_W), .EXP_W(DBL_EXP)) dblCmp_i (
    .a(opA), .b(opB), .cc(dblCc), .anyNan(dblNan)
  );

  always_comb begin
    selCc  = strb.useDouble ? dblCc  : sglCc;
    selNan = strb.useDouble ? dblNan : sglNan;
    fault  = strb.signalling && selNan;
    mergedStatus = statusIn;
    mergedStatus[CC_LSB +: 2] = selCc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid   <= 1'b0;
      ccWritten   <= 1'b0;
      invalidTrap <= 1'b0;
      illegalOp   <= 1'b0;
      statusOut   <= '0;
    end else begin
      doneValid   <= strb.load;
      ccWritten   <= strb.load && !strb.illegal && !fault;
      invalidTrap <= strb.load && !strb.illegal && fault;
      illegalOp   <= strb.load && strb.illegal;
      if (strb.load)
        statusOut <= (strb.illegal || fault) ? statusIn : mergedStatus;
    end
  end

  // R5
  keep_other_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (((statusOut ^ $past(statusIn)) & ~CC_MASK) == '0));

  // R4
  no_update_on_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (invalidTrap || illegalOp) |-> (statusOut == $past(statusIn)));

  // R9
  done_follows_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $past(strb.load));

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !doneValid |-> $stable(statusOut));

  // R6
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid == ($countones({ccWritten, invalidTrap, illegalOp}) == 1));

  // R3
  no_unordered_when_signalling_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ccWritten && $past(strb.signalling)) |-> (statusOut[CC_LSB +: 2] != CC_UN));

endmodule

// File: rtl/fcc_top.sv
module fcc_top
  import fcc_pkg::*;
#(
  parameter int SGL_W   = 32,
  parameter int SGL_EXP = 8,
  parameter int DBL_W   = 64,
  parameter int DBL_EXP = 11,
  parameter int STAT_W  = 32,
  parameter int CC_LSB  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [8:0]        opField,
  input  logic [DBL_W-1:0]  opA,
  input  logic [DBL_W-1:0]  opB,
  input  logic [STAT_W-1:0] statusIn,
  output logic              doneValid,
  output logic              ccWritten,
  output logic              invalidTrap,
  output logic              illegalOp,
  output logic [STAT_W-1:0] statusOut
);

  fccStrobe_t strb;

  fcc_ctrl ctrl_i (
    .startValid(startValid),
    .opField   (opField),
    .strb      (strb)
  );

  fcc_datapath #(
    .SGL_W(SGL_W), .SGL_EXP(SGL_EXP), .DBL_W(DBL_W), .DBL_EXP(DBL_EXP),
    .STAT_W(STAT_W), .CC_LSB(CC_LSB)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .opA        (opA),
    .opB        (opB),
    .statusIn   (statusIn),
    .doneValid  (doneValid),
    .ccWritten  (ccWritten),
    .invalidTrap(invalidTrap),
    .illegalOp  (illegalOp),
    .statusOut  (statusOut)
  );

endmodule

// File: tb/fcc_top_tb_top.sv
module fcc_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        startValid;
  logic [8:0]  opField;
  logic [63:0] opA, opB;
  logic [31:0] statusIn;
  logic        doneValid, ccWritten, invalidTrap, illegalOp;
  logic [31:0] statusOut;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [31:0] st;
    logic ccw, trp, ill;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  logic [31:0] lastStatus = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcc_top dut_i (
    .clk(clk), .rstN(rstN), .startValid(startValid), .opField(opField),
    .opA(opA), .opB(opB), .statusIn(statusIn), .doneValid(doneValid),
    .ccWritten(ccWritten), .invalidTrap(invalidTrap), .illegalOp(illegalOp),
    .statusOut(statusOut)
  );

  // Constants
  localparam logic [31:0] S_ONE = 32'h3F80_0000, S_TWO = 32'h4000_0000;
  localparam logic [31:0] S_MONE = 32'hBF80_0000, S_MTWO = 32'hC000_0000;
  localparam logic [31:0] S_PZ = 32'h0, S_NZ = 32'h8000_0000;
  localparam logic [31:0] S_NAN = 32'h7FC0_0000, S_INF = 32'h7F80_0000;
  localparam logic [31:0] S_MINF = 32'hFF80_0000;
  localparam logic [63:0] D_ONE = 64'h3FF0_0000_0000_0000, D_TWO = 64'h4000_0000_0000_0000;
  localparam logic [63:0] D_MONE = 64'hBFF0_0000_0000_0000, D_MTWO = 64'hC000_0000_0000_0000;
  localparam logic [63:0] D_NZ = 64'h8000_0000_0000_0000, D_NAN = 64'h7FF8_0000_0000_0000;

  function automatic logic [63:0] widen(logic [31:0] x);
    if (x[30:23] == 8'h00)      return {x[31], 63'b0};
    else if (x[30:23] == 8'hFF) return {x[31], 11'h7FF, x[22:0], 29'b0};
    else                        return {x[31], 11'(x[30:23]) + 11'd896, x[22:0], 29'b0};
  endfunction

  function automatic bit refNan(logic [63:0] x, bit dbl);
    if (dbl) return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
    else     return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic logic [1:0] refCc(logic [63:0] a, logic [63:0] b, bit dbl);
    real ra, rb;
    if (refNan(a, dbl) || refNan(b, dbl)) return 2'd3;
    ra = $bitstoreal(dbl ? a : widen(a[31:0]));
    rb = $bitstoreal(dbl ? b : widen(b[31:0]));
    if (ra < rb) return 2'd1;
    if (ra > rb) return 2'd2;
    return 2'd0;
  endfunction

  // Driver: one request per call, expected result pushed to the scoreboard
  task automatic issue(input logic [8:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic [31:0] st, input string tag);
    exp_t e;
    bit dbl, sig, legal, nan;
    @(negedge clk);
    startValid = 1'b1; opField = op; opA = a; opB = b; statusIn = st;
    legal = (op == 9'h051) || (op == 9'h052) || (op == 9'h055) || (op == 9'h056);
    dbl   = (op == 9'h052) || (op == 9'h056);
    sig   = (op == 9'h055) || (op == 9'h056);
    nan   = refNan(a, dbl) || refNan(b, dbl);
    e.st = st; e.ccw = 1'b0; e.trp = 1'b0; e.ill = 1'b0;
    if (!legal) e.ill = 1'b1;
    else if (sig && nan) e.trp = 1'b1;
    else begin
      e.ccw = 1'b1;
      e.st[11:10] = refCc(a, b, dbl);
    end
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      startValid = 1'b0;
      opA = {2{32'hFFFF_FFFF}};
      statusIn = 32'h1234_5678;
    end
  endtask

  // Monitor: compares results as they appear
  initial begin
    exp_t e;
    string t;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (doneValid) begin
          checks++;
          if (expQ.size() == 0) begin
            fails++;
            $display("FAIL R9: unexpected result pulse, actual doneValid=1 expected 0");
          end else begin
            e = expQ.pop_front();
            t = tagQ.pop_front();
            if (statusOut !== e.st || ccWritten !== e.ccw || invalidTrap !== e.trp ||
                illegalOp !== e.ill) begin
              fails++;
              $display("FAIL %s: actual st=%h ccw=%b trp=%b ill=%b expected st=%h ccw=%b trp=%b ill=%b",
                       t, statusOut, ccWritten, invalidTrap, illegalOp, e.st, e.ccw, e.trp, e.ill);
            end
            lastStatus = e.st;
          end
        end else begin
          checks++;
          if (statusOut !== lastStatus || ccWritten || invalidTrap || illegalOp) begin
            fails++;
            $display("FAIL R9: idle hold, actual st=%h flags=%b%b%b expected st=%h flags=000",
                     statusOut, ccWritten, invalidTrap, illegalOp, lastStatus);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual run still busy expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; startValid = 1'b0; opField = '0; opA = '0; opB = '0; statusIn = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    checks++;
    if (statusOut !== 32'h0 || doneValid || ccWritten || invalidTrap || illegalOp) begin
      fails++;
      $display("FAIL R10: actual st=%h v=%b expected st=0 all low", statusOut, doneValid);
    end
    rstN = 1'b1;

    // R2 basic ordering, single and double
    issue(9'h051, {32'h0, S_ONE}, {32'h0, S_TWO}, 32'h0, "R2");
    issue(9'h051, {32'h0, S_TWO}, {32'h0, S_ONE}, 32'h0, "R2");
    issue(9'h051, {32'h0, S_ONE}, {32'h0, S_ONE}, 32'h0000_0C00, "R2");
    issue(9'h052, D_TWO, D_ONE, 32'h0, "R2");
    issue(9'h052, D_ONE, D_ONE, 32'h0000_0800, "R2");
    idle(2);
    // R8 negatives and infinities
    issue(9'h051, {32'h0, S_MONE}, {32'h0, S_MTWO}, 32'h0, "R8");
    issue(9'h051, {32'h0, S_MTWO}, {32'h0, S_MONE}, 32'h0, "R8");
    issue(9'h051, {32'h0, S_MONE}, {32'h0, S_ONE}, 32'h0, "R8");
    issue(9'h051, {32'h0, S_MINF}, {32'h0, S_MTWO}, 32'h0, "R8");
    issue(9'h052, D_MTWO, D_MONE, 32'h0, "R8");
    issue(9'h052, D_ONE, D_MONE, 32'h0, "R8");
    // R7 signed zeros
    issue(9'h051, {32'h0, S_PZ}, {32'h0, S_NZ}, 32'h0000_0400, "R7");
    issue(9'h052, D_NZ, 64'h0, 32'h0000_0C00, "R7");
    idle(1);
    // R3 unordered
    issue(9'h051, {32'h0, S_NAN}, {32'h0, S_ONE}, 32'h0, "R3");
    issue(9'h052, D_ONE, D_NAN, 32'hF000_000F, "R3");
    issue(9'h051, {32'h0, S_INF}, {32'h0, 32'h7F80_0001}, 32'h0, "R3");
    // R4 signalling
    issue(9'h055, {32'h0, S_NAN}, {32'h0, S_ONE}, 32'hA5A5_5A5A, "R4");
    issue(9'h056, D_NAN, D_NAN, 32'h0000_0C00, "R4");
    issue(9'h055, {32'h0, S_INF}, {32'h0, S_ONE}, 32'h0, "R4");
    issue(9'h056, D_MONE, D_ONE, 32'h0, "R4");
    idle(3);
    // R6 illegal selectors
    issue(9'h053, {32'h0, S_ONE}, {32'h0, S_TWO}, 32'hDEAD_BEEF, "R6");
    issue(9'h000, D_ONE, D_TWO, 32'h0000_0400, "R6");
    issue(9'h1FF, D_ONE, D_TWO, 32'h1357_9BDF, "R6");
    // R1 single ignores upper half; same pattern as double differs
    issue(9'h051, {32'hFFFF_FFFF, S_ONE}, {32'h0000_0000, S_TWO}, 32'h0, "R1");
    issue(9'h055, {32'h7FF8_0000, S_TWO}, {32'h0, S_ONE}, 32'h0, "R1");
    issue(9'h052, {32'hBFF0_0000, 32'h0}, {32'h3FF0_0000, 32'h0}, 32'h0, "R1");
    // R5 preserve other bits
    issue(9'h051, {32'h0, S_TWO}, {32'h0, S_ONE}, 32'hFFFF_FFFF, "R5");
    issue(9'h052, D_MONE, D_ONE, 32'h8000_0001, "R5");
    idle(5);

    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R9: actual %0d results missing expected 0", expQ.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule